// File: doc/BRIEF.md
# Instruction Bundle Start-Marker Prefix Decoder

Each 192-bit instruction bundle opens with a short prefix that says, for every 12-bit unit after it, whether an instruction begins there. The markers are not stored as a bitmask. They are stored as packed small-radix digits. This block unpacks that prefix. It returns a start mask and the supplementary opcode bit of each instruction; a fetch/decode front end inserts that bit into the opcode between its upper and lower three bits. The block also returns a flag that says whether the last instruction of the bundle continues into the next bundle.

Two encodings are supported, chosen per bundle by a mode input:

- **Ternary mode.** The prefix is three bytes, with five base-3 digits in each byte.
- **Quinary mode.** The prefix is five 7-bit groups, with three base-5 digits in each group, followed by one pad bit. Each digit can also mark its instruction as dependent on earlier instructions in the bundle.

In both modes there are fifteen digits. Digit k, for k from 1 to 14, describes instruction slot k−1. In ternary mode that slot is 12-bit unit k+2 of the bundle. Digit 15 refers to the first instruction unit of the following bundle. It is used only to decide the carry-over flag.

Bundle bit 191 is the first bit of the bundle.

A bundle offered with `valid_i` high is decoded and registered. The result is shown for exactly one cycle with `res_valid_o` high. A small two-state controller runs this:

- **ST_IDLE:** no result is shown and all outputs are zero.
- **ST_EMIT:** the captured result is driven.

The transitions are:

- ST_IDLE→ST_EMIT when `valid_i` is high.
- ST_EMIT→ST_EMIT when `valid_i` is high again (back-to-back bundles).
- ST_EMIT→ST_IDLE when `valid_i` is low.
- ST_IDLE→ST_IDLE when `valid_i` is low.

Top module: `prefix_start_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid_o`, all masks, `spill_o` and `bad_code_o` are 0.
- R2: When `valid_i` is high at a clock edge, the decoded result of that bundle is on the outputs with `res_valid_o` = 1 from that edge until the next one. If `valid_i` was low at an edge, `res_valid_o` is 0 after it.
- R3: Ternary mode (`quin_mode_i` = 0) unpacks digits as follows:
  - Bundle bits [191:184], [183:176] and [175:168] hold digits 1–5, 6–10 and 11–15 as base-3 numbers, with the first digit of each byte most significant.
  - For digits 1..14, a nonzero digit k sets `start_o[k-1]`, and the value 2 also sets `supp_o[k-1]`.
  - `dep_o` is 0.
- R4: Quinary mode (`quin_mode_i` = 1) unpacks digits as follows:
  - Bundle bits [191:185], [184:178], … [163:157] hold digits 1–3, 4–6, … 13–15 as base-5 numbers, with the first digit of each group most significant.
  - For digits 1..14, a nonzero digit k sets `start_o[k-1]`.
  - The values 2 and 4 set `supp_o[k-1]`.
  - The values 3 and 4 set `dep_o[k-1]`.
- R5: `spill_o` is 1 exactly when digit 15 is 0. The nonzero value of digit 15 (supplementary bit, dependency) changes no output.
- R6: In ternary mode, any prefix byte of value 243 or more gives `bad_code_o` = 1 with the start, supplementary and dependency masks and `spill_o` all 0.
- R7: In quinary mode, any 7-bit group of value 125 or more gives `bad_code_o` = 1 with the start, supplementary and dependency masks and `spill_o` all 0.
- R8: In quinary mode, bundle bit 156 (the pad bit) set to 1 gives `bad_code_o` = 1 with all masks and `spill_o` 0.
- R9: Bundle bits below the prefix (below 168 in ternary mode, below 156 in quinary mode) do not affect any output.
- R10: `bad_code_o` and every mask bit are 0 whenever `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bundle_i | input | 192 | Instruction bundle; bit 191 is the first bit |
| valid_i | input | 1 | Bundle present this cycle |
| quin_mode_i | input | 1 | 0: ternary prefix, 1: quinary prefix with dependency flags |
| res_valid_o | output | 1 | Decoded result shown this cycle |
| start_o | output | 14 | Instruction begins in slot i |
| supp_o | output | 14 | Supplementary opcode bit of the instruction in slot i |
| dep_o | output | 14 | Instruction in slot i depends on earlier ones (quinary only) |
| spill_o | output | 1 | Last instruction continues into the next bundle |
| bad_code_o | output | 1 | Prefix contains an out-of-range code |

## Verification
The bench first checks uniform digit fields (all 0, all 1, all 2, all 4). These separate the start decision from the supplementary and dependency decisions, and they also place each group exactly at its largest legal code. Mixed digit patterns in both modes show that the most-significant-first digit order and the slot numbering are right. Repeating the same prefix with different values for digit 15 and for the trailing bits shows that those bits only steer the carry-over flag, or nothing at all. Out-of-range codes are injected into the first, middle and last group, plus a set pad bit. Back-to-back and gapped bundles show that the one-cycle presentation and the quiet idle outputs hold.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    // Width of one unpacked digit (holds values 0..4)
    localparam int DIGIT_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;
endpackage

// File: rtl/digit_group_unpack.sv
module digit_group_unpack #(
    parameter int RADIX = 3,
    parameter int NDIG  = 5,
    parameter int GW    = 8,
    parameter int DW    = 3
) (
    input  logic [GW-1:0]            code_i,
    output logic [NDIG-1:0][DW-1:0]  digs_o,   // index 0 = most significant digit
    output logic                     bad_o
);
    localparam int LIMIT = RADIX ** NDIG;

    logic [GW-1:0] rem;

    always_comb begin
        rem   = code_i;
        bad_o = ({1'b0, code_i} >= (GW+1)'(LIMIT));
        for (int j = NDIG - 1; j >= 0; j--) begin
            digs_o[j] = DW'(rem % GW'(RADIX));
            rem       = rem / GW'(RADIX);
        end
    end
endmodule

// File: rtl/prefix_field_decode.sv
module prefix_field_decode #(
    parameter int RADIX  = 3,
    parameter int PER    = 5,
    parameter int GW     = 8,
    parameter int NGROUP = 3,
    parameter int DW     = 3,
    localparam int FIELD_W = NGROUP * GW,
    localparam int NDIG    = NGROUP * PER
) (
    input  logic [FIELD_W-1:0]        field_i,
    output logic [NDIG-1:0][DW-1:0]   digits_o,
    output logic                      bad_o
);
    logic [NGROUP-1:0] grp_bad;

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        logic [PER-1:0][DW-1:0] gd;
        digit_group_unpack #(
            .RADIX (RADIX),
            .NDIG  (PER),
            .GW    (GW),
            .DW    (DW)
        ) u_unpack (
            .code_i (field_i[(NGROUP-g)*GW-1 -: GW]),
            .digs_o (gd),
            .bad_o  (grp_bad[g])
        );
        assign digits_o[g*PER +: PER] = gd;
    end

    assign bad_o = |grp_bad;
endmodule

// File: rtl/digit_to_flags.sv
module digit_to_flags #(
    parameter int NDIG = 15,
    parameter int DW   = 3,
    localparam int NSLOT = NDIG - 1
) (
    input  logic                     quin_i,
    input  logic [NDIG-1:0][DW-1:0]  digits_i,
    output logic [NSLOT-1:0]         start_o,
    output logic [NSLOT-1:0]         supp_o,
    output logic [NSLOT-1:0]         dep_o,
    output logic                     spill_o
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [DW-1:0] d;
        assign d = digits_i[i];
        always_comb begin
            start_o[i] = (d != '0);
            if (quin_i) begin
                supp_o[i] = (d == DW'(2)) || (d == DW'(4));
                dep_o[i]  = (d == DW'(3)) || (d == DW'(4));
            end else begin
                supp_o[i] = (d == DW'(2));
                dep_o[i]  = 1'b0;
            end
        end
    end

    assign spill_o = (digits_i[NDIG-1] == '0);
endmodule

// File: rtl/prefix_start_decoder.sv
module prefix_start_decoder
    import bpd_pkg::*;
#(
    parameter int BUNDLE_W    = 192,
    parameter int TERN_GROUPS = 3,
    parameter int TERN_GW     = 8,
    parameter int TERN_PER    = 5,
    parameter int QUIN_GROUPS = 5,
    parameter int QUIN_GW     = 7,
    parameter int QUIN_PER    = 3,
    parameter int PAD_BITS    = 1,
    localparam int NUM_DIG    = TERN_GROUPS * TERN_PER,
    localparam int NUM_SLOT   = NUM_DIG - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUNDLE_W-1:0]  bundle_i,
    input  logic                 valid_i,
    input  logic                 quin_mode_i,
    output logic                 res_valid_o,
    output logic [NUM_SLOT-1:0]  start_o,
    output logic [NUM_SLOT-1:0]  supp_o,
    output logic [NUM_SLOT-1:0]  dep_o,
    output logic                 spill_o,
    output logic                 bad_code_o
);
    localparam int TERN_W     = TERN_GROUPS * TERN_GW;
    localparam int QUIN_W     = QUIN_GROUPS * QUIN_GW;
    localparam int QUIN_PFX_W = QUIN_W + PAD_BITS;

    // ---------------- field unpacking ----------------
    logic [NUM_DIG-1:0][DIGIT_W-1:0] tern_dig, quin_dig, sel_dig;
    logic                            tern_bad, quin_grp_bad, quin_bad;
    logic [PAD_BITS-1:0]             pad_bits;
    logic                            unused_tail;

    prefix_field_decode #(
        .RADIX (3), .PER (TERN_PER), .GW (TERN_GW),
        .NGROUP (TERN_GROUPS), .DW (DIGIT_W)
    ) u_tern (
        .field_i  (bundle_i[BUNDLE_W-1 -: TERN_W]),
        .digits_o (tern_dig),
        .bad_o    (tern_bad)
    );

    prefix_field_decode #(
        .RADIX (5), .PER (QUIN_PER), .GW (QUIN_GW),
        .NGROUP (QUIN_GROUPS), .DW (DIGIT_W)
    ) u_quin (
        .field_i  (bundle_i[BUNDLE_W-1 -: QUIN_W]),
        .digits_o (quin_dig),
        .bad_o    (quin_grp_bad)
    );

    assign pad_bits    = bundle_i[BUNDLE_W-QUIN_W-1 -: PAD_BITS];
    assign quin_bad    = quin_grp_bad | (|pad_bits);
    assign unused_tail = ^bundle_i[BUNDLE_W-QUIN_PFX_W-1:0];
    assign sel_dig     = quin_mode_i ? quin_dig : tern_dig;

    // ---------------- flag derivation ----------------
    logic [NUM_SLOT-1:0] nx_start, nx_supp, nx_dep;
    logic                nx_spill, nx_bad;

    digit_to_flags #(.NDIG (NUM_DIG), .DW (DIGIT_W)) u_flags (
        .quin_i   (quin_mode_i),
        .digits_i (sel_dig),
        .start_o  (nx_start),
        .supp_o   (nx_supp),
        .dep_o    (nx_dep),
        .spill_o  (nx_spill)
    );

    assign nx_bad = quin_mode_i ? quin_bad : tern_bad;

    // ---------------- controller ----------------
    emit_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (valid_i)  state_d = ST_EMIT;
            ST_EMIT: if (!valid_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured result
    logic [NUM_SLOT-1:0] r_start, r_supp, r_dep;
    logic                r_spill, r_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_start <= '0;
            r_supp  <= '0;
            r_dep   <= '0;
            r_spill <= 1'b0;
            r_bad   <= 1'b0;
        end else if (valid_i) begin
            if (nx_bad) begin
                r_start <= '0;
                r_supp  <= '0;
                r_dep   <= '0;
                r_spill <= 1'b0;
                r_bad   <= 1'b1;
            end else begin
                r_start <= nx_start;
                r_supp  <= nx_supp;
                r_dep   <= nx_dep;
                r_spill <= nx_spill;
                r_bad   <= 1'b0;
            end
        end
    end

    // output process
    always_comb begin
        res_valid_o = 1'b0;
        start_o     = '0;
        supp_o      = '0;
        dep_o       = '0;
        spill_o     = 1'b0;
        bad_code_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: begin
                res_valid_o = 1'b1;
                start_o     = r_start;
                supp_o      = r_supp;
                dep_o       = r_dep;
                spill_o     = r_spill;
                bad_code_o  = r_bad;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prefix_start_decoder_chk.sv
module prefix_start_decoder_chk #(
    parameter int NUM_SLOT = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic                quin_mode_i,
    input logic                res_valid_o,
    input logic [NUM_SLOT-1:0] start_o,
    input logic [NUM_SLOT-1:0] supp_o,
    input logic [NUM_SLOT-1:0] dep_o,
    input logic                spill_o,
    input logic                bad_code_o
);
    p_emit_follows_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);

    p_quiet_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !res_valid_o);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (start_o == '0 && supp_o == '0 && dep_o == '0 && !spill_o && !bad_code_o));

    p_supp_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ((supp_o & ~start_o) == '0));

    p_dep_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ((dep_o & ~start_o) == '0));

    p_tern_no_dep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !quin_mode_i) |=> (dep_o == '0));

    p_err_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code_o |-> (start_o == '0 && supp_o == '0 && dep_o == '0 && !spill_o));
endmodule

bind prefix_start_decoder prefix_start_decoder_chk #(.NUM_SLOT (14)) u_chk (.*);

// File: tb/sim_prefix_start_decoder.sv
module sim_prefix_start_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 14;
    localparam int VW = 1 + 3*NS + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [191:0]  bundle = '0;
    logic          valid = 1'b0;
    logic          quin = 1'b0;
    logic          res_valid, spill, bad;
    logic [NS-1:0] start, supp, dep;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int dig [15];
    logic [VW-1:0] exp_vec = '0;
    string exp_tag = "R1 reset state";

    prefix_start_decoder u0 (
        .clk (clk), .rst_n (rst_n), .bundle_i (bundle), .valid_i (valid),
        .quin_mode_i (quin), .res_valid_o (res_valid), .start_o (start),
        .supp_o (supp), .dep_o (dep), .spill_o (spill), .bad_code_o (bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [191:0] pack_tern(input logic [191:0] fill);
        logic [191:0] r = fill;
        for (int b = 0; b < 3; b++) begin
            int v = 0;
            for (int j = 0; j < 5; j++) v = v*3 + dig[5*b+j];
            r[191-8*b -: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic logic [191:0] pack_quin(input logic [191:0] fill);
        logic [191:0] r = fill;
        for (int g = 0; g < 5; g++) begin
            int v = 0;
            for (int j = 0; j < 3; j++) v = v*5 + dig[3*g+j];
            r[191-7*g -: 7] = 7'(v);
        end
        r[156] = 1'b0;
        return r;
    endfunction

    task automatic check_prev();
        logic [VW-1:0] act;
        @(negedge clk);
        act = {res_valid, start, supp, dep, spill, bad};
        checks++;
        if (act !== exp_vec) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", exp_tag, act, exp_vec);
        end
    endtask

    task automatic send(input bit q, input logic [191:0] b, input bit exp_err, input string tag);
        logic [NS-1:0] es = '0, ep = '0, ed = '0;
        check_prev();
        bundle = b; quin = q; valid = 1'b1;
        for (int i = 0; i < NS; i++) begin
            if (dig[i] != 0) es[i] = 1'b1;
            if (dig[i] == 2 || (q && dig[i] == 4)) ep[i] = 1'b1;
            if (q && dig[i] >= 3) ed[i] = 1'b1;
        end
        if (exp_err) exp_vec = {1'b1, {3*NS{1'b0}}, 1'b0, 1'b1};
        else         exp_vec = {1'b1, es, ep, ed, (dig[14] == 0), 1'b0};
        exp_tag = tag;
    endtask

    task automatic idle(input string tag);
        check_prev();
        valid = 1'b0;
        bundle = {6{32'hDEAD_BEEF}};
        exp_vec = '0;
        exp_tag = tag;
    endtask

    task automatic fill_dig(input int mul, input int add, input int radix);
        for (int i = 0; i < 15; i++) dig[i] = (i*mul + add) % radix;
    endtask

    localparam logic [191:0] FILL_A = {6{32'h5A5A_C3C3}};
    localparam logic [191:0] FILL_B = {192{1'b1}};

    initial begin
        logic [191:0] b;
        repeat (3) @(posedge clk);
        check_prev();                         // R1 during reset
        @(negedge clk) rst_n = 1'b1;
        exp_tag = "R1 first cycle after reset";
        idle("R1 idle after reset");

        // ---------- ternary ----------
        fill_dig(0, 0, 3);
        send(0, pack_tern(FILL_A), 0, "R3/R5 ternary all zero, spill");
        fill_dig(0, 1, 3); dig[14] = 2;
        send(0, pack_tern(FILL_A), 0, "R3 ternary all one");
        fill_dig(0, 2, 3);
        send(0, pack_tern(FILL_A), 0, "R3/R6 ternary all two, byte 242");
        fill_dig(7, 1, 3);
        send(0, pack_tern(FILL_A), 0, "R3 ternary mixed digits");
        dig[14] = 1;
        send(0, pack_tern(FILL_A), 0, "R5 ternary digit15=1");
        dig[14] = 2;
        send(0, pack_tern(FILL_A), 0, "R5 ternary digit15=2 same masks");
        send(0, pack_tern(FILL_B), 0, "R9 ternary trailing bits ignored");
        fill_dig(5, 2, 3);
        send(0, pack_tern('0), 0, "R3 ternary second mix");
        idle("R10 idle after ternary");
        idle("R2 gap quiet");

        fill_dig(7, 1, 3);
        b = pack_tern(FILL_A); b[191:184] = 8'd243;
        send(0, b, 1, "R6 ternary byte0=243");
        b = pack_tern(FILL_A); b[183:176] = 8'd255;
        send(0, b, 1, "R6 ternary byte1=255");
        b = pack_tern(FILL_A); b[175:168] = 8'd250;
        send(0, b, 1, "R6 ternary byte2=250");
        b = pack_tern(FILL_A); b[156] = 1'b1;
        send(0, b, 0, "R9 ternary ignores bit 156");

        // ---------- quinary ----------
        fill_dig(0, 0, 5);
        send(1, pack_quin(FILL_A), 0, "R4/R5 quinary all zero");
        fill_dig(0, 4, 5);
        send(1, pack_quin(FILL_A), 0, "R4/R7 quinary all four, group 124");
        fill_dig(1, 0, 5);
        send(1, pack_quin(FILL_A), 0, "R4 quinary ascending digits");
        fill_dig(2, 1, 5);
        send(1, pack_quin(FILL_A), 0, "R4 quinary odd pattern");
        dig[14] = 3;
        send(1, pack_quin(FILL_A), 0, "R5 quinary digit15=3");
        dig[14] = 0;
        send(1, pack_quin(FILL_A), 0, "R5 quinary digit15=0 spill");
        fill_dig(3, 2, 5);
        b = pack_quin(FILL_B); b[156] = 1'b0;
        send(1, b, 0, "R9 quinary trailing bits ignored");
        idle("R2 quinary gap");

        b = pack_quin(FILL_A); b[191:185] = 7'd125;
        send(1, b, 1, "R7 quinary group0=125");
        b = pack_quin(FILL_A); b[163:157] = 7'd127;
        send(1, b, 1, "R7 quinary group4=127");
        b = pack_quin(FILL_A); b[156] = 1'b1;
        send(1, b, 1, "R8 quinary pad bit set");
        fill_dig(1, 3, 5);
        send(1, pack_quin(FILL_A), 0, "R2 back-to-back after error");
        fill_dig(7, 1, 3);
        send(0, pack_tern(FILL_A), 0, "R2 back-to-back mode switch");
        idle("R2 result held one cycle only");
        idle("R10 outputs quiet");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule